// File: doc/BRIEF.md
# One-Shot Activity-Controlled 64-bit ALU

This block is a 64-bit arithmetic logic unit. A 4-bit opcode picks one of sixteen functions, and the function is applied to two operands. Each rising edge of a request input starts exactly one computation. The datapath register loads only while that computation is pending. This is done with a synchronous clock-enable, which stands in for a gated clock. Between computations the result register is frozen and the operand and opcode inputs have no effect.

A request works as follows:

1. The host raises `enable_i`.
2. The edge that sees `enable_i` high in the armed state moves the unit to a compute state.
3. The next edge evaluates the opcode and operands that are present at that edge, loads the result and raises `done_o`.
4. The unit then waits for `enable_i` to be low. Only after that can it be armed again.

Holding the request high therefore yields one result, not a stream of results.

Top module: `oneshot_alu`

## Requirements
- R1: Reset (`rst_i`, active high, asynchronous) forces `result_o` to zero and `done_o` to 0 immediately, without waiting for a clock edge.
- R2: From the armed state, `enable_i` sampled high at edge k causes `result_o` to be loaded and `done_o` to rise at edge k+1. With `enable_i` low, the unit stays armed and nothing changes.
- R3: Bitwise opcodes give the following results: 4'b0001 A&B, 4'b0010 ~(A&B), 4'b0011 A|B, 4'b0100 ~(A|B), 4'b0101 A^B, 4'b0110 ~(A^B), 4'b1101 ~A.
- R4: Arithmetic opcodes wrap modulo 2^64 and have no carry output: 4'b0111 A+B, 4'b1000 A-B, 4'b1001 B-A, 4'b1011 A+1, 4'b1100 A-1, 4'b1110 0-A.
- R5: Opcode 4'b1010 returns the low 64 bits of the 128-bit product A*B.
- R6: Opcode 4'b1111 returns A shifted left by one bit, with zero entering bit 0.
- R7: Opcode 4'b0000 leaves `result_o` unchanged but still completes the cycle and raises `done_o`.
- R8: While `enable_i` stays high after a result, no further computation occurs: `done_o` stays 1 and `result_o` holds, whatever the opcode or operands do.
- R9: The first edge that sees `enable_i` low while `done_o` is high clears `done_o` and re-arms the unit, so a new request is then accepted.
- R10: Opcode and operands are used only at the compute edge (edge k+1 in R2). Values present at the arming edge, while idle, or while waiting for release do not affect `result_o`.
- R11: Opcode 4'b0111 with A = 64'h4400000000004321 and B = 64'h3300000000001234 yields 64'h7700000000005555.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| enable_i | input | 1 | Request; one computation per high phase |
| opcode_i | input | 4 | Operation select |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| result_o | output | 64 | Registered result |
| done_o | output | 1 | High from the result edge until re-arm or reset |

## Verification
The hardest cases to reach from the ports are the cycle between the arming edge and the compute edge, and a request held high after the result.

- For the first case, the stimulus arms the unit with one opcode and one pair of operands. It then swaps both for different ones half a cycle before the compute edge. Only the late values may appear in the result.
- For the second case, the bench keeps `enable_i` high for several cycles and scrambles the opcode and operands in every cycle. The scoreboard must then see exactly one `done_o` rise, and `result_o` must stay frozen until release.

// File: rtl/oneshot_alu_pkg.sv
package oneshot_alu_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'b0000,
        OP_AND    = 4'b0001,
        OP_NAND   = 4'b0010,
        OP_OR     = 4'b0011,
        OP_NOR    = 4'b0100,
        OP_XOR    = 4'b0101,
        OP_XNOR   = 4'b0110,
        OP_ADD    = 4'b0111,
        OP_SUB_AB = 4'b1000,
        OP_SUB_BA = 4'b1001,
        OP_MUL    = 4'b1010,
        OP_INC    = 4'b1011,
        OP_DEC    = 4'b1100,
        OP_INV    = 4'b1101,
        OP_NEG    = 4'b1110,
        OP_SHL    = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'b00,
        ST_COMPUTE = 2'b01,
        ST_RELEASE = 2'b10
    } arm_state_e;

    typedef struct packed {
        arm_state_e state;
    } ctrl_regs_t;

endpackage

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
    import oneshot_alu_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    output logic load_o,
    output logic done_o
);

    ctrl_regs_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_ARMED:   if (enable_i) ctrl_d.state = ST_COMPUTE;
            ST_COMPUTE: ctrl_d.state = ST_RELEASE;
            ST_RELEASE: if (!enable_i) ctrl_d.state = ST_ARMED;
            default:    ctrl_d.state = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            ctrl_q <= '{state: ST_ARMED};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_o = (ctrl_q.state == ST_COMPUTE);
    assign done_o = (ctrl_q.state == ST_RELEASE);

    AST_ARM_NEEDS_REQUEST: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_o && !done_o && !enable_i) |=> (!load_o && !done_o)); // R2
    AST_LOAD_THEN_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |=> (done_o && !load_o)); // R2
    AST_HELD_NO_RETRIGGER: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && enable_i) |=> (done_o && !load_o)); // R8
    AST_RELEASE_REARMS: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !enable_i) |=> (!done_o && !load_o)); // R9

endmodule

// File: rtl/oneshot_alu_core.sv
module oneshot_alu_core
    import oneshot_alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [3:0]       opcode_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] value_o,
    output logic             write_o
);

    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    alu_op_e          op;
    logic [WIDTH-1:0] product;

    assign op      = alu_op_e'(opcode_i);
    assign product = opa_i * opb_i;

    always_comb begin
        write_o = 1'b1;
        unique case (op)
            OP_NOP: begin
                value_o = ZERO;
                write_o = 1'b0;
            end
            OP_AND:    value_o = opa_i & opb_i;
            OP_NAND:   value_o = ~(opa_i & opb_i);
            OP_OR:     value_o = opa_i | opb_i;
            OP_NOR:    value_o = ~(opa_i | opb_i);
            OP_XOR:    value_o = opa_i ^ opb_i;
            OP_XNOR:   value_o = ~(opa_i ^ opb_i);
            OP_ADD:    value_o = opa_i + opb_i;
            OP_SUB_AB: value_o = opa_i - opb_i;
            OP_SUB_BA: value_o = opb_i - opa_i;
            OP_MUL:    value_o = product;
            OP_INC:    value_o = opa_i + ONE;
            OP_DEC:    value_o = opa_i - ONE;
            OP_INV:    value_o = ~opa_i;
            OP_NEG:    value_o = ZERO - opa_i;
            OP_SHL:    value_o = {opa_i[WIDTH-2:0], 1'b0};
            default:   value_o = ZERO;
        endcase
    end

endmodule

// File: rtl/oneshot_alu.sv
module oneshot_alu
    import oneshot_alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             enable_i,
    input  logic [3:0]       opcode_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);

    typedef struct packed {
        logic [WIDTH-1:0] result;
    } dp_regs_t;

    dp_regs_t         dp_d, dp_q;
    logic             load;
    logic             write;
    logic [WIDTH-1:0] value;

    oneshot_ctrl ctrl_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .enable_i (enable_i),
        .load_o   (load),
        .done_o   (done_o)
    );

    oneshot_alu_core #(.WIDTH(WIDTH)) core_i (
        .opcode_i (opcode_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .value_o  (value),
        .write_o  (write)
    );

    always_comb begin
        dp_d = dp_q;
        if (load && write) begin
            dp_d.result = value;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign result_o = dp_q.result;

    AST_FROZEN_UNLESS_COMPUTE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(result_o) |-> $past(load)); // R10
    AST_NOP_KEEPS_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
        (load && opcode_i == OP_NOP) |=> ($stable(result_o) && done_o)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> $stable(result_o)); // R8

endmodule

// File: tb/oneshot_alu_tb_top.sv
`timescale 1ns/1ps
module oneshot_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [3:0]  opcode = 4'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [63:0] result;
    logic        done;

    int compared = 0;
    int mismatched = 0;
    logic [63:0] model_result = '0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic        done_prev = 1'b0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    oneshot_alu dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .enable_i (enable),
        .opcode_i (opcode),
        .opa_i    (opa),
        .opb_i    (opb),
        .result_o (result),
        .done_o   (done)
    );

    function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] prev);
        case (op)
            4'h0: return prev;
            4'h1: return a & b;
            4'h2: return ~(a & b);
            4'h3: return a | b;
            4'h4: return ~(a | b);
            4'h5: return a ^ b;
            4'h6: return ~(a ^ b);
            4'h7: return a + b;
            4'h8: return a - b;
            4'h9: return b - a;
            4'hA: return a * b;
            4'hB: return a + 64'd1;
            4'hC: return a - 64'd1;
            4'hD: return ~a;
            4'hE: return 64'd0 - a;
            default: return {a[62:0], 1'b0};
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: pops one expected item per rising done
    always @(negedge clk) begin
        if (rst) begin
            done_prev <= 1'b0;
        end else begin
            if (done && !done_prev) begin
                if (exp_q.size() == 0) begin
                    chk("R8 spurious done", result, 64'hX);
                end else begin
                    chk(tag_q.pop_front(), result, exp_q.pop_front());
                end
            end
            done_prev <= done;
        end
    end

    // Driver: hold = extra cycles enable stays high after the result
    task automatic run_op(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                          input string tag, input int hold);
        logic [63:0] exp;
        exp = model(op, a, b, model_result);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        opcode = op; opa = a; opb = b; enable = 1'b1;
        @(negedge clk);
        chk({tag, " R2 no done before compute"}, 64'(done), 64'd0);
        if (hold == 0) enable = 1'b0;
        @(negedge clk);
        chk({tag, " R2 done raised"}, 64'(done), 64'd1);
        for (int i = 0; i < hold; i++) begin
            opcode = 4'(i + 3); opa = ~a ^ 64'(i); opb = b + 64'(i);
            @(negedge clk);
            chk("R8 done held", 64'(done), 64'd1);
            chk("R8 result frozen", result, exp);
        end
        enable = 1'b0;
        @(negedge clk);
        chk({tag, " R9 done cleared"}, 64'(done), 64'd0);
        model_result = exp;
    endtask

    // Arm with one set of inputs, switch before the compute edge
    task automatic run_late(input logic [3:0] op0, input logic [63:0] a0, input logic [63:0] b0,
                            input logic [3:0] op1, input logic [63:0] a1, input logic [63:0] b1);
        logic [63:0] exp;
        exp = model(op1, a1, b1, model_result);
        exp_q.push_back(exp);
        tag_q.push_back("R10 late operands used");
        @(negedge clk);
        opcode = op0; opa = a0; opb = b0; enable = 1'b1;
        @(negedge clk);
        opcode = op1; opa = a1; opb = b1; enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model_result = exp;
    endtask

    initial begin
        #40000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset done", 64'(done), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 idle without enable", 64'(done), 64'd0);

        run_op(4'h7, 64'h4400000000004321, 64'h3300000000001234, "R11 example add", 0);
        chk("R11 example value", result, 64'h7700000000005555);

        for (int p = 0; p < 2; p++) begin
            logic [63:0] a, b;
            a = (p == 0) ? 64'hF0F0_1234_AAAA_0001 : 64'h0123_4567_89AB_CDEF;
            b = (p == 0) ? 64'h0FF0_FFFF_5555_8001 : 64'hFEDC_BA98_7654_3210;
            run_op(4'h1, a, b, "R3 and", 0);
            run_op(4'h2, a, b, "R3 nand", 0);
            run_op(4'h3, a, b, "R3 or", 0);
            run_op(4'h4, a, b, "R3 nor", 0);
            run_op(4'h5, a, b, "R3 xor", 0);
            run_op(4'h6, a, b, "R3 xnor", 0);
            run_op(4'hD, a, b, "R3 invert", 0);
        end

        run_op(4'h7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R4 add wrap", 0);
        chk("R4 add wrap zero", result, 64'd0);
        run_op(4'h8, 64'd0, 64'd1, "R4 sub wrap", 0);
        run_op(4'h9, 64'd5, 64'd3, "R4 b minus a", 0);
        run_op(4'hB, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, "R4 increment wrap", 0);
        run_op(4'hC, 64'd0, 64'd7, "R4 decrement wrap", 0);
        run_op(4'hE, 64'd0, 64'd7, "R4 negate zero", 0);
        run_op(4'hE, 64'd1, 64'd7, "R4 negate one", 0);

        run_op(4'hA, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, "R5 multiply low half", 0);
        run_op(4'hA, 64'h0000_0001_0000_0003, 64'h0000_0001_0000_0005, "R5 multiply cross", 0);

        run_op(4'hF, 64'h8000_0000_0000_0001, 64'd0, "R6 shift", 0);
        chk("R6 shift value", result, 64'd2);

        run_op(4'h0, 64'h1234, 64'h5678, "R7 nop keeps", 0);

        run_op(4'h3, 64'h00F0, 64'h0F00, "R8 held request", 6);
        run_op(4'h5, 64'hAAAA, 64'h5555, "R9 rearm accepted", 0);

        run_late(4'h1, 64'hFFFF, 64'h0, 4'h8, 64'd100, 64'd58);

        for (int i = 0; i < 4; i++) begin
            opcode = 4'(i * 5); opa = 64'(i) * 64'h1111; opb = ~opa;
            @(negedge clk);
        end
        chk("R10 idle changes ignored", result, model_result);
        chk("R10 no done while idle", 64'(done), 64'd0);

        run_op(4'h7, 64'h10, 64'h20, "R1 pre reset", 0);
        #1 rst = 1'b1;
        #0.5;
        chk("R1 async reset result", result, 64'd0);
        chk("R1 async reset done", 64'(done), 64'd0);
        model_result = '0;
        @(negedge clk);
        rst = 1'b0;
        run_op(4'h0, 64'h99, 64'h99, "R7 nop after reset", 0);

        repeat (3) @(negedge clk);
        chk("R2 all results delivered", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule